// File: doc/BRIEF.md
# Command Ring Word Fetcher

This block pulls 32-bit command words out of a circular buffer held in system memory and hands them, one per transfer, to a downstream packet decoder. Software programs the ring's base address, its size and an optional report address. It then moves a write index forward. Whenever the write index differs from the block's own read index, the block issues memory reads from the read position onward. The read index wraps to zero at the end of the ring. Words in memory are stored most-significant byte first, and the block reverses their byte order before presenting them.

The decoder can ask the block to run one secondary (indirect) buffer by giving a pointer and a word count. The block keeps the top address bits of the ring base and takes the remaining bits from the pointer. It fetches the requested number of words from that address and then carries on with the ring where it left off. Only one such buffer may be active at a time. A second request while one runs is dropped and raises a sticky error flag. When the ring has drained and the report address is non-zero, the block writes the current read index to that address so that software can see how far the ring was consumed.

Top module: `cmd_ring_fetch`

## Requirements
- R1: Ring word k is fetched from byte address base + 4*k. Configuration selects are: 0 = ring base, 1 = ring size in bytes (word count = value/4), 2 = report address, 3 = write index (a word index).
- R2: Fetching runs while read index differs from write index, producing exactly (write - read) mod ring-words words in ring order. A memory request, once raised, holds its address and stays raised until granted.
- R3: The read index advances by one per ring word and wraps from ring-words - 1 to 0.
- R4: An indirect buffer starting address is bits 31:29 of the ring base concatenated with bits 28:0 of the supplied pointer; successive words come from consecutive word addresses.
- R5: An indirect request of length N yields exactly N words, then fetching resumes at the saved ring read position. A zero length yields no words. An indirect request accepted in the same cycle as a write-index update is served before the ring words.
- R6: After the ring drains following at least one ring word, a single memory write of the read index to the report address is issued, only when the report address is non-zero.
- R7: Each output word is the fetched memory word with its four bytes in reverse order.
- R8: An indirect request made while an indirect buffer is active is ignored (no extra words) and sets the sticky nest_err output.
- R9: idle is 1 exactly when read index equals write index, no indirect buffer is active, no report write is due and no memory transaction is open; it falls in the cycle after the write index is moved away from the read index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_wdata | input | 32 | Configuration write value |
| ib_req | input | 1 | Indirect buffer request pulse |
| ib_ptr | input | 32 | Indirect buffer pointer |
| ib_len | input | 16 | Indirect buffer length in words |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data, stored MSB first |
| out_valid | output | 1 | Command word valid |
| out_word | output | 32 | Byte-reversed command word |
| rd_idx | output | 16 | Current ring read index |
| nest_err | output | 1 | Sticky nested-request error |
| idle | output | 1 | Fetcher has nothing to do |

## Verification
A read index that drifts shows up on the next fetch as a wrong memory address, and so as a wrong output word, and it shows up again in the value written to the report address once the ring drains. A lost or doubled indirect count changes how many words appear before the ring resumes, so word counts and ordering are compared after each scenario. A stuck indirect-active state keeps idle low and makes a following legal request raise nest_err, both visible within a few cycles.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
  parameter int ADDR_W   = 32;
  parameter int WORD_W   = 32;
  parameter int IDX_W    = 16;
  parameter int LEN_W    = 16;
  parameter int WIN_BITS = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RDREQ = 2'd1,
    ST_RDWAIT = 2'd2,
    ST_WBREQ = 2'd3
  } fetch_state_e;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_SIZE = 2'd1,
    SEL_RPT  = 2'd2,
    SEL_WIDX = 2'd3
  } cfg_sel_e;

  function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] idx,
                                                input logic [IDX_W-1:0] words);
    logic [IDX_W:0] nxt;
    nxt = {1'b0, idx} + 1'b1;
    if (nxt >= {1'b0, words}) idx_step = '0;
    else idx_step = nxt[IDX_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] ring_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    ring_addr = base + {{(ADDR_W-IDX_W-2){1'b0}}, idx, 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] rebase(input logic [ADDR_W-1:0] base,
                                               input logic [ADDR_W-1:0] ptr);
    rebase = {base[ADDR_W-1 -: WIN_BITS], ptr[ADDR_W-WIN_BITS-1:0]};
  endfunction
endpackage

// File: rtl/cmdring_regs.sv
module cmdring_regs
  import cmdring_pkg::*;
#(
  parameter int DEF_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              ring_word_done,
  output logic [ADDR_W-1:0] base,
  output logic [IDX_W-1:0]  ring_words,
  output logic [ADDR_W-1:0] rpt_addr,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [IDX_W-1:0]  rd_idx
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_wdata[WORD_W-1:IDX_W+2], cfg_wdata[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base       <= '0;
      ring_words <= IDX_W'(DEF_WORDS);
      rpt_addr   <= '0;
      wr_idx     <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_BASE: base       <= cfg_wdata[ADDR_W-1:0];
        SEL_SIZE: ring_words <= cfg_wdata[IDX_W+1:2];
        SEL_RPT:  rpt_addr   <= cfg_wdata[ADDR_W-1:0];
        default:  wr_idx     <= cfg_wdata[IDX_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_idx <= '0;
    else if (ring_word_done) rd_idx <= idx_step(rd_idx, ring_words);
  end

  // R3: the last slot of the ring is followed by slot zero
  p_rd_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_word_done && ring_words != '0 && rd_idx == ring_words - 1'b1
     && !(cfg_we && cfg_sel == SEL_SIZE)) |=> rd_idx == '0);
endmodule

// File: rtl/cmdring_swap.sv
module cmdring_swap #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;
  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign dout[8*g +: 8] = din[8*(NB-1-g) +: 8];
  end
endmodule

// File: rtl/cmdring_seq.sv
module cmdring_seq
  import cmdring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] rpt_addr,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              ib_req,
  input  logic [ADDR_W-1:0] ib_ptr,
  input  logic [LEN_W-1:0]  ib_len,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  output logic              word_valid,
  output logic              ring_word_done,
  output logic              nest_err,
  output logic              idle
);
  fetch_state_e state, state_nx;
  logic              ib_active;
  logic [ADDR_W-1:0] ib_addr;
  logic [LEN_W-1:0]  ib_remain;
  logic              src_ib;
  logic              rpt_due;

  // named internal events
  logic ib_accept, nest_reject, ib_word_done, ib_finish;
  logic go_ib, go_ring, go_rpt, rpt_drop, rpt_sent;

  assign ib_accept   = ib_req && !ib_active;
  assign nest_reject = ib_req && ib_active;
  assign word_valid  = (state == ST_RDWAIT) && mem_rvalid;
  assign ib_word_done   = word_valid && src_ib;
  assign ring_word_done = word_valid && !src_ib;
  assign ib_finish = (state == ST_IDLE) && ib_active && (ib_remain == '0);

  always_comb begin
    go_ib = 1'b0; go_ring = 1'b0; go_rpt = 1'b0; rpt_drop = 1'b0;
    if (state == ST_IDLE) begin
      if (ib_active) go_ib = (ib_remain != '0);
      else if (rpt_due && rd_idx == wr_idx) begin
        if (rpt_addr != '0) go_rpt = 1'b1;
        else rpt_drop = 1'b1;
      end else if (rd_idx != wr_idx) go_ring = 1'b1;
    end
  end
  assign rpt_sent = (state == ST_WBREQ) && mem_gnt;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:   if (go_ib || go_ring) state_nx = ST_RDREQ;
                 else if (go_rpt) state_nx = ST_WBREQ;
      ST_RDREQ:  if (mem_gnt) state_nx = ST_RDWAIT;
      ST_RDWAIT: if (mem_rvalid) state_nx = ST_IDLE;
      default:   if (mem_gnt) state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mem_addr  <= '0;
      mem_wdata <= '0;
      src_ib    <= 1'b0;
    end else begin
      state <= state_nx;
      if (go_ib) begin
        mem_addr <= ib_addr;
        src_ib   <= 1'b1;
      end else if (go_ring) begin
        mem_addr <= ring_addr(base, rd_idx);
        src_ib   <= 1'b0;
      end else if (go_rpt) begin
        mem_addr  <= rpt_addr;
        mem_wdata <= {{(WORD_W-IDX_W){1'b0}}, rd_idx};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ib_active <= 1'b0;
      ib_addr   <= '0;
      ib_remain <= '0;
    end else if (ib_accept) begin
      ib_active <= 1'b1;
      ib_addr   <= rebase(base, ib_ptr);
      ib_remain <= ib_len;
    end else if (ib_finish) begin
      ib_active <= 1'b0;
    end else if (ib_word_done) begin
      ib_addr   <= ib_addr + ADDR_W'(4);
      ib_remain <= ib_remain - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rpt_due <= 1'b0;
    else if (ring_word_done) rpt_due <= 1'b1;
    else if (rpt_sent || rpt_drop) rpt_due <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) nest_err <= 1'b0;
    else if (nest_reject) nest_err <= 1'b1;
  end

  assign mem_req = (state == ST_RDREQ) || (state == ST_WBREQ);
  assign mem_we  = (state == ST_WBREQ);
  assign idle = (state == ST_IDLE) && !ib_active && !rpt_due && (rd_idx == wr_idx);

  // R2: an ungranted request keeps its address
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
  // R4: indirect reads stay in the ring's upper address window
  p_ib_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && src_ib) |-> mem_addr[ADDR_W-1 -: WIN_BITS] == base[ADDR_W-1 -: WIN_BITS]);
  // R6: no report write to address zero
  p_rpt_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_addr != '0);
  // R8: a nested request leaves the error flag set
  p_nest_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nest_reject |=> nest_err);
  // R9: an idle fetcher has no open memory traffic
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mem_req);
endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
  import cmdring_pkg::*;
#(
  parameter int DEF_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              ib_req,
  input  logic [ADDR_W-1:0] ib_ptr,
  input  logic [LEN_W-1:0]  ib_len,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              nest_err,
  output logic              idle
);
  logic [ADDR_W-1:0] base, rpt_addr;
  logic [IDX_W-1:0]  ring_words, wr_idx;
  logic              ring_word_done;

  cmdring_regs #(.DEF_WORDS(DEF_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ring_word_done(ring_word_done), .base(base),
    .ring_words(ring_words), .rpt_addr(rpt_addr), .wr_idx(wr_idx), .rd_idx(rd_idx)
  );

  cmdring_seq u_seq (
    .clk(clk), .rst_n(rst_n), .base(base), .rpt_addr(rpt_addr), .wr_idx(wr_idx),
    .rd_idx(rd_idx), .ib_req(ib_req), .ib_ptr(ib_ptr), .ib_len(ib_len),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .word_valid(out_valid),
    .ring_word_done(ring_word_done), .nest_err(nest_err), .idle(idle)
  );

  cmdring_swap #(.W(WORD_W)) u_swap (.din(mem_rdata), .dout(out_word));
endmodule

// File: tb/sim_cmd_ring_fetch.sv
`timescale 1ns/1ps
module sim_cmd_ring_fetch;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0; logic [1:0] cfg_sel = '0; logic [31:0] cfg_wdata = '0;
  logic ib_req = 1'b0; logic [31:0] ib_ptr = '0; logic [15:0] ib_len = '0;
  logic mem_req, mem_we, mem_gnt, mem_rvalid, out_valid, nest_err, idle;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, out_word;
  logic [15:0] rd_idx;

  int n_chk = 0, n_fail = 0;
  logic [31:0] got [0:255];
  int n_got = 0;
  int n_wr = 0;
  logic [31:0] wr_a, wr_d;
  localparam logic [31:0] BASE = 32'h2000_0100;

  always #4 clk = ~clk;

  cmd_ring_fetch u0 (.*);

  function automatic logic [31:0] mdat(input logic [31:0] a);
    return a ^ 32'hA5C3_1E00;
  endfunction
  function automatic logic [31:0] rev(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  assign mem_gnt = mem_req;
  always @(posedge clk) begin
    if (!rst_n) mem_rvalid <= 1'b0;
    else mem_rvalid <= mem_req && !mem_we;
    mem_rdata <= mdat(mem_addr);
    if (rst_n && mem_req && mem_we) begin
      n_wr <= n_wr + 1; wr_a <= mem_addr; wr_d <= mem_wdata;
    end
  end
  always @(negedge clk) if (out_valid && n_got < 256) begin
    got[n_got] <= out_word; n_got <= n_got + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic ib(input logic [31:0] p, input logic [15:0] l);
    @(negedge clk); ib_req = 1'b1; ib_ptr = p; ib_len = l;
    @(negedge clk); ib_req = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    repeat (2) @(negedge clk);
    while (!idle && t < 2000) begin @(negedge clk); t++; end
    chk(idle, req, 32'(t), 32'd2000);
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_word(input int k, input logic [31:0] a, input string req);
    chk(got[k] == rev(mdat(a)), req, got[k], rev(mdat(a)));
  endtask

  task automatic t_reset;
    chk(idle == 1'b1, "R9 reset idle", 32'(idle), 1);
    chk(rd_idx == 0, "R3 reset index", 32'(rd_idx), 0);
    chk(nest_err == 1'b0, "R8 reset flag", 32'(nest_err), 0);
    chk(mem_req == 1'b0, "R2 reset request", 32'(mem_req), 0);
  endtask

  task automatic t_basic;
    int s;
    cfg(2'd0, BASE); cfg(2'd1, 32'd64); cfg(2'd2, 32'd0);
    s = n_got;
    cfg(2'd3, 32'd4);
    wait_idle("R2 drain");
    chk(n_got - s == 4, "R2 word count", 32'(n_got - s), 4);
    for (int k = 0; k < 4; k++) expect_word(s + k, BASE + 32'(4*k), "R1 R7 ring word");
    chk(rd_idx == 4, "R3 index", 32'(rd_idx), 4);
    chk(n_wr == 0, "R6 no report at zero address", 32'(n_wr), 0);
  endtask

  task automatic t_wrap;
    int s = n_got;
    cfg(2'd3, 32'd2);
    wait_idle("R3 drain");
    chk(n_got - s == 14, "R3 wrap count", 32'(n_got - s), 14);
    for (int k = 0; k < 14; k++)
      expect_word(s + k, BASE + 32'(4*((4 + k) % 16)), "R3 wrap order");
    chk(rd_idx == 2, "R3 wrapped index", 32'(rd_idx), 2);
  endtask

  task automatic t_report;
    int s = n_got;
    cfg(2'd2, 32'h2000_0400);
    cfg(2'd3, 32'd5);
    wait_idle("R6 drain");
    chk(n_got - s == 3, "R6 words", 32'(n_got - s), 3);
    chk(n_wr == 1, "R6 one report write", 32'(n_wr), 1);
    chk(wr_a == 32'h2000_0400, "R6 report address", wr_a, 32'h2000_0400);
    chk(wr_d == 32'd5, "R6 report value", wr_d, 5);
  endtask

  task automatic t_indirect;
    int s = n_got;
    ib(32'hE000_0300, 16'd3);
    wait_idle("R5 drain");
    chk(n_got - s == 3, "R5 indirect count", 32'(n_got - s), 3);
    for (int k = 0; k < 3; k++) expect_word(s + k, 32'h2000_0300 + 32'(4*k), "R4 rebased word");
    chk(rd_idx == 5, "R5 ring index kept", 32'(rd_idx), 5);
    chk(n_wr == 1, "R6 no report for indirect", 32'(n_wr), 1);
  endtask

  task automatic t_nest;
    int s = n_got;
    ib(32'h0000_0800, 16'd6);
    ib(32'h0000_0C00, 16'd4);
    wait_idle("R8 drain");
    chk(n_got - s == 6, "R8 nested ignored", 32'(n_got - s), 6);
    for (int k = 0; k < 6; k++) expect_word(s + k, 32'h2000_0800 + 32'(4*k), "R8 first buffer words");
    chk(nest_err == 1'b1, "R8 error flag", 32'(nest_err), 1);
  endtask

  task automatic t_zero;
    int s = n_got;
    ib(32'h0000_0900, 16'd0);
    wait_idle("R5 zero drain");
    chk(n_got - s == 0, "R5 zero length", 32'(n_got - s), 0);
  endtask

  task automatic t_resume;
    int s = n_got;
    @(negedge clk);
    ib_req = 1'b1; ib_ptr = 32'h0000_0040; ib_len = 16'd2;
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'd7;
    @(negedge clk);
    ib_req = 1'b0; cfg_we = 1'b0;
    chk(idle == 1'b0, "R9 idle drops", 32'(idle), 0);
    wait_idle("R5 resume drain");
    chk(n_got - s == 4, "R5 resume count", 32'(n_got - s), 4);
    expect_word(s + 0, 32'h2000_0040, "R5 indirect first");
    expect_word(s + 1, 32'h2000_0044, "R5 indirect second");
    expect_word(s + 2, BASE + 32'd20, "R5 ring resumes");
    expect_word(s + 3, BASE + 32'd24, "R5 ring resumes");
    chk(wr_d == 32'd7, "R6 report after resume", wr_d, 7);
  endtask

  initial begin
    #(8 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_wrap;
    t_report;
    t_indirect;
    t_nest;
    t_zero;
    t_resume;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule